// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block owns a small processor's program counter, its status word and a stack pointer. It runs the hardware steps that enter and leave an interrupt service routine. A request pulse is latched as pending. The block acts on it only when the processor signals that an instruction has completed and the interrupt-enable bit of the status word is set. To enter, it saves the current program counter and then the status word on a stack in memory that grows toward lower addresses. It then switches the status word to supervisor mode with interrupts masked, and loads the vector address into the program counter.

A return command reverses the sequence. The status word is read back first, then the program counter, and the stack pointer climbs by two. While a sequence is in flight the block raises a busy output, and it ignores the processor's own writes to the program counter and status word. Each memory access takes one cycle. Read data is expected on the cycle after the read strobe.

Status word encoding (6 bits): bit 0 carry, bit 1 sign, bit 2 zero, bit 3 overflow, bit 4 interrupt enable, bit 5 supervisor. When the status word is pushed, it fills the low six bits of the stack word and the upper bits are zero.

Top module: `irq_seq_top`

## Requirements
- R1: An entry starts only in a cycle where `instr_done` is high, a request is pending and status bit 4 (interrupt enable) is 1. `busy` then rises on the next cycle. No entry starts without the strobe.
- R2: On entry, the old PC is written to address SP-1 in the first busy cycle and the old status word to SP-2 in the second busy cycle. SP ends two lower.
- R3: On entry, the PC holds `vec_addr` from the third clock edge after the accepting cycle. This is the first cycle with `busy` low again.
- R4: On entry, the status word that is pushed is the value before entry. Afterwards bit 4 is 0, bit 5 is 1, and bits 0 to 3 are unchanged.
- R5: A request pulse stays pending while no entry occurs, including boundaries where interrupt enable is 0. It is taken at the first later boundary with enable 1. It is cleared by the entry that serves it.
- R6: On `ret_cmd`, the word at SP is read and restored to the status word (low 6 bits). The word at SP+1 is then read and restored to the PC. SP ends two higher and the saved state is restored exactly. Nested frames unwind in last-in, first-out order.
- R7: `busy` is high for exactly three cycles per entry and per return. It is never high together with both memory strobes.
- R8: `pc_ld`/`psw_ld` update PC/status on the next edge when idle. They are ignored while `busy` is high.
- R9: After reset: PC = 0, status = 0, SP = 0xF0 (default), `busy` = 0, and no memory strobe.
- R10: If `ret_cmd` and a takeable entry condition occur in the same cycle, the return runs first. The pending request is served at a later boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_done | input | 1 | Instruction-boundary strobe |
| irq_req | input | 1 | Interrupt request pulse |
| ret_cmd | input | 1 | Return-from-interrupt command |
| vec_addr | input | DW | Service routine start address |
| pc_ld | input | 1 | Processor write of the PC |
| pc_in | input | DW | PC write value |
| psw_ld | input | 1 | Processor write of the status word |
| psw_in | input | 6 | Status word write value |
| pc_o | output | DW | Program counter |
| psw_o | output | 6 | Status word |
| sp_o | output | AW | Stack pointer |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | AW | Stack address |
| mem_wdata | output | DW | Stack write data |
| mem_rdata | input | DW | Stack read data, valid one cycle after `mem_re` |
| busy | output | 1 | Sequence in progress |

## Verification
If the sequencer sits in a wrong state, the fault shows at the memory port within one cycle. A write to a wrong address or in the wrong order, a read where a write belongs, or a busy window that is not three cycles long is caught by the write scoreboard and the busy checks. A corrupted pending latch or stack pointer stays hidden until the next boundary or the next return. It then shows as a missing or extra frame, or as a restored PC or status word that does not match the bench's own frame stack. For this reason the bench nests two frames and ends every scenario by unwinding to the starting state.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int PSW_W   = 6;
  localparam int BIT_C   = 0;
  localparam int BIT_S   = 1;
  localparam int BIT_Z   = 2;
  localparam int BIT_V   = 3;
  localparam int BIT_IE  = 4;
  localparam int BIT_SUP = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PC,
    ST_PUSH_PSW,
    ST_VEC,
    ST_POP_PSW,
    ST_POP_PC,
    ST_LOAD_PC
  } seq_st_e;
endpackage

// File: rtl/irq_seq_rsync.sv
module irq_seq_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_ni = chain[STAGES-1];
endmodule

// File: rtl/irq_seq_pend.sv
module irq_seq_pend (
  input  logic clk,
  input  logic rst_ni,
  input  logic irq_req,
  input  logic clr,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = (pend_q & ~clr) | irq_req;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R5: a pending request survives every cycle that does not serve it
  a_r5_pend_held: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_q && !clr) |=> pend_q);
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_ni,
  input  logic    instr_done,
  input  logic    ret_cmd,
  input  logic    irq_pend,
  input  logic    ie,
  output seq_st_e state_o,
  output logic    pend_clr,
  output logic    busy_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (ret_cmd)                          st_d = ST_POP_PSW;
        else if (instr_done && irq_pend && ie) st_d = ST_PUSH_PC;
      end
      ST_PUSH_PC:  st_d = ST_PUSH_PSW;
      ST_PUSH_PSW: st_d = ST_VEC;
      ST_VEC:      st_d = ST_IDLE;
      ST_POP_PSW:  st_d = ST_POP_PC;
      ST_POP_PC:   st_d = ST_LOAD_PC;
      ST_LOAD_PC:  st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o  = st_q;
  assign pend_clr = (st_q == ST_VEC);
  assign busy_o   = (st_q != ST_IDLE);

  // R2: the status push follows the PC push directly
  a_r2_push_order: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_PUSH_PC) |=> (st_q == ST_PUSH_PSW));
  // R6: the PC pop follows the status pop directly
  a_r6_pop_order: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_POP_PSW) |=> (st_q == ST_POP_PC));
  // R10: a return command wins over an entry in the same cycle
  a_r10_ret_first: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_IDLE && ret_cmd) |=> (st_q == ST_POP_PSW));
  // R1: no entry while interrupts are masked
  a_r1_masked: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_IDLE && !ret_cmd && !ie) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/irq_seq_regs.sv
module irq_seq_regs
  import irq_seq_pkg::*;
#(
  parameter int DW            = 16,
  parameter int AW            = 8,
  parameter logic [DW-1:0] PC_RST = '0,
  parameter logic [AW-1:0] SP_RST = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  seq_st_e          state,
  input  logic             pc_ld,
  input  logic [DW-1:0]    pc_in,
  input  logic             psw_ld,
  input  logic [PSW_W-1:0] psw_in,
  input  logic [DW-1:0]    vec_addr,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DW-1:0]    pc_o,
  output logic [PSW_W-1:0] psw_o,
  output logic [AW-1:0]    sp_o,
  output logic             mem_we,
  output logic             mem_re,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata
);
  localparam int PAD_W = DW - PSW_W;

  logic [DW-1:0]    pc_q, pc_d;
  logic [PSW_W-1:0] psw_q, psw_d;
  logic [AW-1:0]    sp_q, sp_d;
  logic             pc_en, psw_en, sp_en;
  logic             idle;
  logic [AW-1:0]    sp_dn, sp_up;

  assign idle  = (state == ST_IDLE);
  assign sp_dn = sp_q - 1'b1;
  assign sp_up = sp_q + 1'b1;

  // stack port
  always_comb begin
    mem_we    = (state == ST_PUSH_PC) || (state == ST_PUSH_PSW);
    mem_re    = (state == ST_POP_PSW) || (state == ST_POP_PC);
    mem_addr  = mem_we ? sp_dn : sp_q;
    mem_wdata = (state == ST_PUSH_PC) ? pc_q : {{PAD_W{1'b0}}, psw_q};
  end

  // next-state for the three registers
  always_comb begin
    sp_en = mem_we || mem_re;
    sp_d  = mem_we ? sp_dn : sp_up;

    pc_en = 1'b0;
    pc_d  = pc_q;
    if (idle && pc_ld) begin
      pc_en = 1'b1;
      pc_d  = pc_in;
    end else if (state == ST_VEC) begin
      pc_en = 1'b1;
      pc_d  = vec_addr;
    end else if (state == ST_LOAD_PC) begin
      pc_en = 1'b1;
      pc_d  = mem_rdata;
    end

    psw_en = 1'b0;
    psw_d  = psw_q;
    if (idle && psw_ld) begin
      psw_en = 1'b1;
      psw_d  = psw_in;
    end else if (state == ST_VEC) begin
      psw_en          = 1'b1;
      psw_d[BIT_IE]   = 1'b0;
      psw_d[BIT_SUP]  = 1'b1;
    end else if (state == ST_POP_PC) begin
      psw_en = 1'b1;
      psw_d  = mem_rdata[PSW_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= PC_RST;
      psw_q <= '0;
      sp_q  <= SP_RST;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (psw_en) psw_q <= psw_d;
      if (sp_en)  sp_q  <= sp_d;
    end
  end

  assign pc_o  = pc_q;
  assign psw_o = psw_q;
  assign sp_o  = sp_q;

  // R2: every stack write moves SP one place down
  a_r2_push_dec: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_we |=> (sp_q == AW'($past(sp_q) - 1'b1)));
  // R6: every stack read moves SP one place up
  a_r6_pop_inc: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_re |=> (sp_q == AW'($past(sp_q) + 1'b1)));
  // R3: the vector reaches the PC
  a_r3_vector: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_VEC) |=> (pc_q == $past(vec_addr)));
  // R4: entry masks interrupts and selects supervisor mode, flags kept
  a_r4_mode: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_VEC) |=> (!psw_q[BIT_IE] && psw_q[BIT_SUP] &&
                           psw_q[BIT_V:BIT_C] == $past(psw_q[BIT_V:BIT_C])));
  // R8: processor loads have no effect while a push or the first pop runs
  a_r8_pc_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_PUSH_PC || state == ST_PUSH_PSW || state == ST_POP_PSW)
      |=> $stable(pc_q));
  // R7: never read and write in one cycle
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_ni)
    !(mem_we && mem_re));
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
  import irq_seq_pkg::*;
#(
  parameter int DW            = 16,
  parameter int AW            = 8,
  parameter logic [DW-1:0] PC_RST = '0,
  parameter logic [AW-1:0] SP_RST = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_done,
  input  logic             irq_req,
  input  logic             ret_cmd,
  input  logic [DW-1:0]    vec_addr,
  input  logic             pc_ld,
  input  logic [DW-1:0]    pc_in,
  input  logic             psw_ld,
  input  logic [PSW_W-1:0] psw_in,
  output logic [DW-1:0]    pc_o,
  output logic [PSW_W-1:0] psw_o,
  output logic [AW-1:0]    sp_o,
  output logic             mem_we,
  output logic             mem_re,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             busy
);
  logic    rst_ni;
  logic    pend, pend_clr;
  seq_st_e state;

  irq_seq_rsync #(.STAGES(2)) u_rsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  irq_seq_pend u_pend (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .irq_req (irq_req),
    .clr     (pend_clr),
    .pend_o  (pend)
  );

  irq_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .instr_done (instr_done),
    .ret_cmd    (ret_cmd),
    .irq_pend   (pend),
    .ie         (psw_o[BIT_IE]),
    .state_o    (state),
    .pend_clr   (pend_clr),
    .busy_o     (busy)
  );

  irq_seq_regs #(
    .DW     (DW),
    .AW     (AW),
    .PC_RST (PC_RST),
    .SP_RST (SP_RST)
  ) u_regs (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .state     (state),
    .pc_ld     (pc_ld),
    .pc_in     (pc_in),
    .psw_ld    (psw_ld),
    .psw_in    (psw_in),
    .vec_addr  (vec_addr),
    .mem_rdata (mem_rdata),
    .pc_o      (pc_o),
    .psw_o     (psw_o),
    .sp_o      (sp_o),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  // R1: a sequence starts only from a boundary strobe or a return command
  a_r1_start: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy) |-> $past(instr_done || ret_cmd));
  // R7: the first busy cycle carries a stack access
  a_r7_first_access: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy) |-> (mem_we || mem_re));
endmodule

// File: tb/sim_irq_seq_top.sv
module sim_irq_seq_top;
  localparam int DW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          instr_done, irq_req, ret_cmd, pc_ld, psw_ld;
  logic [DW-1:0] vec_addr, pc_in, mem_rdata, pc_o, mem_wdata;
  logic [5:0]    psw_in, psw_o;
  logic [AW-1:0] sp_o, mem_addr;
  logic          mem_we, mem_re, busy;

  always #2.5 clk = ~clk;

  irq_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .irq_req(irq_req),
    .ret_cmd(ret_cmd), .vec_addr(vec_addr), .pc_ld(pc_ld), .pc_in(pc_in),
    .psw_ld(psw_ld), .psw_in(psw_in), .pc_o(pc_o), .psw_o(psw_o),
    .sp_o(sp_o), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy)
  );

  // stack memory model, one-cycle read
  logic [DW-1:0] ram [0:(1<<AW)-1];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard of expected stack writes
  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
  wr_t exp_q[$];

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) chk("R2 unexpected write", {8'h0, mem_addr, mem_wdata}, 32'h0);
      else begin
        wr_t e;
        e = exp_q.pop_front();
        chk("R2 write", {8'h0, mem_addr, mem_wdata}, {8'h0, e.a, e.d});
      end
    end
  end

  // bench model of architectural state
  logic [DW-1:0] m_pc;
  logic [5:0]    m_psw;
  logic [AW-1:0] m_sp;
  logic [DW-1:0] f_pc[$];
  logic [5:0]    f_psw[$];

  task automatic cyc(); @(negedge clk); endtask

  task automatic load(input logic [DW-1:0] p, input logic [5:0] s);
    pc_ld = 1; pc_in = p; psw_ld = 1; psw_in = s;
    cyc();
    pc_ld = 0; psw_ld = 0;
    m_pc = p; m_psw = s;
    cyc();
    chk("R8 pc load", pc_o, m_pc);
    chk("R8 psw load", psw_o, m_psw);
  endtask

  task automatic enter(input logic [DW-1:0] v);
    vec_addr = v;
    exp_q.push_back({AW'(m_sp - 1), m_pc});
    exp_q.push_back({AW'(m_sp - 2), {10'h0, m_psw}});
    f_pc.push_back(m_pc); f_psw.push_back(m_psw);
    instr_done = 1;
    cyc();
    instr_done = 0;
    chk("R1 busy rise", busy, 1);
    pc_ld = 1; pc_in = 16'hDEAD;         // R8 poke while busy
    cyc();
    pc_ld = 0;
    chk("R7 busy 2", busy, 1);
    cyc();
    chk("R7 busy 3", busy, 1);
    chk("R8 pc held", pc_o, m_pc);
    cyc();
    m_pc = v; m_psw = (m_psw & 6'h0F) | 6'h20; m_sp = m_sp - 2;
    chk("R7 busy fall", busy, 0);
    chk("R3 vector", pc_o, m_pc);
    chk("R4 psw mode", psw_o, m_psw);
    chk("R2 sp", sp_o, m_sp);
    chk("R2 all writes", exp_q.size(), 0);
  endtask

  task automatic leave(input bit with_boundary);
    ret_cmd = 1; instr_done = with_boundary;
    cyc();
    ret_cmd = 0; instr_done = 0;
    chk("R6 busy", busy, 1);
    chk("R10 read first", {mem_re, mem_we}, 2'b10);
    chk("R6 pop addr psw", mem_addr, m_sp);
    cyc();
    chk("R6 pop addr pc", mem_addr, AW'(m_sp + 1));
    cyc();
    chk("R7 busy 3", busy, 1);
    cyc();
    m_pc = f_pc.pop_back(); m_psw = f_psw.pop_back(); m_sp = m_sp + 2;
    chk("R7 busy fall", busy, 0);
    chk("R6 pc", pc_o, m_pc);
    chk("R6 psw", psw_o, m_psw);
    chk("R6 sp", sp_o, m_sp);
  endtask

  task automatic pulse_irq();
    irq_req = 1; cyc(); irq_req = 0;
  endtask

  initial begin
    rst_n = 0; instr_done = 0; irq_req = 0; ret_cmd = 0; pc_ld = 0; psw_ld = 0;
    vec_addr = '0; pc_in = '0; psw_in = '0;
    m_pc = '0; m_psw = '0; m_sp = 8'hF0;
    repeat (3) cyc();
    // R9 reset values
    chk("R9 pc", pc_o, 0);
    chk("R9 psw", psw_o, 0);
    chk("R9 sp", sp_o, 8'hF0);
    chk("R9 busy", busy, 0);
    chk("R9 strobes", {mem_we, mem_re}, 0);
    rst_n = 1;
    repeat (3) cyc();

    load(16'h1234, 6'h1F);
    // R1: pending request but no boundary strobe
    pulse_irq();
    repeat (3) begin cyc(); chk("R1 no strobe", busy, 0); end
    enter(16'h0400);

    // R5: request while masked stays pending
    pulse_irq();
    instr_done = 1; cyc(); instr_done = 0;
    cyc();
    chk("R5 masked", busy, 0);
    chk("R5 masked sp", sp_o, m_sp);
    leave(0);
    enter(16'h0500);                     // R5 served once enable returns
    chk("R5 cleared", f_pc.size(), 1);

    // R10: return and boundary in the same cycle
    load(16'h0500, 6'h32);
    pulse_irq();
    leave(1);
    enter(16'h0600);

    // nested frame
    load(16'h0600, 6'h30);
    pulse_irq();
    enter(16'h0700);
    chk("R6 depth", m_sp, 8'hEC);
    leave(0);
    leave(0);
    chk("R6 unwound pc", pc_o, 16'h1234);

    // R5: cleared after service, no second entry
    instr_done = 1; cyc(); instr_done = 0; cyc();
    chk("R5 no repeat", busy, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule